// File: doc/BRIEF.md
# Interrupt Source Aggregator with Pending Queue

This block gathers a group of level-sensitive interrupt lines into a single request line toward an upstream interrupt controller. Firmware decides which lines may take part by setting bits in an enable register. When a chosen line is high while the group is idle, the bits of the lines that fired are latched into a status register and the output request goes high. Events that arrive while firmware is still handling earlier ones are not lost. They are collected in an internal pending vector. When firmware clears the last status bit, the pending bits move into status and the request is raised again.

The enable register has two roles, and the write history decides which one applies. A write that adds new bits grows a sticky enable vector. A write that adds no new bits is read as a mask or unmask command. Bits that turn on unmask their lines, and bits that turn off mask them. While any line is masked, every new event goes to the pending vector. Status is cleared by writing ones. A write of all ones clears the register without any reload, and is used for initialization.

Access is through a word-wide register port with a valid/ready handshake. The enable register is at byte offset 0x0 and status is at byte offset 0x4. Reads return data one cycle after the request.

Top module: `irq_group_agg`

## Requirements
- R1: After reset `irq_o` is low, and reads of the enable register (offset 0x0) and the status register (offset 0x4) return zero. The mask vector and the pending vector are empty.
- R2: A line counts as selected only while it is high and its bit in the sticky enable vector is set. A cycle with no selected line leaves status, pending and `irq_o` unchanged.
- R3: When lines are selected while status is zero and no line is masked, status is loaded with the selected bits and `irq_o` is high from the next cycle.
- R4: When lines are selected while status is nonzero or some line is masked, the selected bits are ORed into pending, and status and `irq_o` are unchanged.
- R5: An enable write of zero while the sticky vector is zero only stores zero. An enable write that adds new bits ORs them into the sticky vector, stores the data as the readable value, and leaves the mask alone.
- R6: An enable write that adds no new sticky bits computes the change as the stored value XOR the data. If the change AND the data is nonzero, the changed bits are unmasked. Otherwise they are masked. The data is then stored.
- R7: A status write of zero has no effect.
- R8: A status write of all ones clears status, leaves pending untouched, and leaves `irq_o` as it was.
- R9: Any other nonzero status write clears the bits written as one. If status becomes zero, one of two things happens. If pending is nonzero, status takes pending, pending is emptied and `irq_o` stays high. If pending is empty, `irq_o` goes low.
- R10: When a register write and selected lines occur in the same cycle, the write is applied first, and the line event is then judged against the updated state.
- R11: `req_ready` is always high. A read request is answered with `rd_valid` high on the next cycle. Offsets other than 0x0 and 0x4 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | W | Level-sensitive interrupt source lines |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset inside the group |
| req_wdata | input | W | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | W | Read data |
| irq_o | output | 1 | Aggregated request toward the upstream controller |

## Verification
The assertions assume that a register request is either a read or a write of one word, and that only one register is touched per cycle. Source lines may change freely on any cycle. Some properties are conditioned on no line being selected in the same cycle, because a write followed by an event in that cycle is a legal outcome that those properties do not cover. The stimulus drives each request for exactly one cycle. It raises source lines on their own and also in the same cycle as status writes, so the ordering rule is exercised directly.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int AGG_W  = 32;
    localparam int AGG_AW = 4;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_EN   = 2'd1,
        SEL_ST   = 2'd2
    } agg_sel_e;
endpackage

// File: rtl/irq_agg_enable.sv
module irq_agg_enable #(
    parameter int W = irq_agg_pkg::AGG_W
) (
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] en_reg_i,
    input  logic [W-1:0] sticky_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] en_reg_o,
    output logic [W-1:0] sticky_o,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] merged;
    logic [W-1:0] diff;

    always_comb begin
        merged   = sticky_i | wdata_i;
        diff     = en_reg_i ^ wdata_i;
        en_reg_o = en_reg_i;
        sticky_o = sticky_i;
        mask_o   = mask_i;
        if (wr_i) begin
            en_reg_o = wdata_i;
            if (!(wdata_i == '0 && sticky_i == '0)) begin
                if (merged != sticky_i) begin
                    sticky_o = merged;
                end else if ((diff & wdata_i) != '0) begin
                    mask_o = mask_i & ~diff;
                end else begin
                    mask_o = mask_i | diff;
                end
            end
        end
    end
endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
    parameter int W = irq_agg_pkg::AGG_W
) (
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] src_i,
    input  logic [W-1:0] sticky_i,
    input  logic [W-1:0] mask_i,
    input  logic [W-1:0] status_i,
    input  logic [W-1:0] pend_i,
    input  logic         irq_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] pend_o,
    output logic         irq_o
);
    logic [W-1:0] picked;

    always_comb begin
        status_o = status_i;
        pend_o   = pend_i;
        irq_o    = irq_i;
        picked   = src_i & sticky_i;
        // write side first
        if (wr_i && wdata_i != '0) begin
            status_o = status_o & ~wdata_i;
            if (wdata_i != '1 && status_o == '0) begin
                if (pend_o != '0) begin
                    status_o = pend_o;
                    pend_o   = '0;
                    irq_o    = 1'b1;
                end else begin
                    irq_o = 1'b0;
                end
            end
        end
        // then the source event against the updated state
        if (picked != '0) begin
            if (mask_i != '0 || status_o != '0) begin
                pend_o = pend_o | picked;
            end else begin
                status_o = picked;
                irq_o    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg #(
    parameter int W  = irq_agg_pkg::AGG_W,
    parameter int AW = irq_agg_pkg::AGG_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  src_i,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [W-1:0]  req_wdata,
    output logic          rd_valid,
    output logic [W-1:0]  rd_data,
    output logic          irq_o
);
    import irq_agg_pkg::*;

    localparam logic [AW-1:0] EN_OFF = AW'(0);
    localparam logic [AW-1:0] ST_OFF = AW'(4);

    typedef struct packed {
        logic [W-1:0] en_reg;
        logic [W-1:0] sticky;
        logic [W-1:0] mask;
        logic [W-1:0] status;
        logic [W-1:0] pend;
        logic         irq;
        logic         rd_valid;
        logic [W-1:0] rd_data;
    } agg_state_t;

    agg_state_t state_d, state_q;
    agg_sel_e   sel;
    logic       wr_en_reg, wr_st_reg;
    logic [W-1:0] en_reg_n, sticky_n, mask_n, status_n, pend_n;
    logic         irq_n;
    logic [W-1:0] status_vec, sticky_vec;

    always_comb begin
        sel = SEL_NONE;
        if (req_valid) begin
            if (req_addr == EN_OFF)      sel = SEL_EN;
            else if (req_addr == ST_OFF) sel = SEL_ST;
        end
    end

    assign wr_en_reg = req_write && (sel == SEL_EN);
    assign wr_st_reg = req_write && (sel == SEL_ST);

    irq_agg_enable #(.W(W)) u_enable (
        .wr_i     (wr_en_reg),
        .wdata_i  (req_wdata),
        .en_reg_i (state_q.en_reg),
        .sticky_i (state_q.sticky),
        .mask_i   (state_q.mask),
        .en_reg_o (en_reg_n),
        .sticky_o (sticky_n),
        .mask_o   (mask_n)
    );

    irq_agg_status #(.W(W)) u_status (
        .wr_i     (wr_st_reg),
        .wdata_i  (req_wdata),
        .src_i    (src_i),
        .sticky_i (sticky_n),
        .mask_i   (mask_n),
        .status_i (state_q.status),
        .pend_i   (state_q.pend),
        .irq_i    (state_q.irq),
        .status_o (status_n),
        .pend_o   (pend_n),
        .irq_o    (irq_n)
    );

    always_comb begin
        state_d          = state_q;
        state_d.en_reg   = en_reg_n;
        state_d.sticky   = sticky_n;
        state_d.mask     = mask_n;
        state_d.status   = status_n;
        state_d.pend     = pend_n;
        state_d.irq      = irq_n;
        state_d.rd_valid = req_valid && !req_write;
        state_d.rd_data  = '0;
        if (req_valid && !req_write) begin
            case (sel)
                SEL_EN:  state_d.rd_data = state_q.en_reg;
                SEL_ST:  state_d.rd_data = state_q.status;
                default: state_d.rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign req_ready  = 1'b1;
    assign rd_valid   = state_q.rd_valid;
    assign rd_data    = state_q.rd_data;
    assign irq_o      = state_q.irq;
    assign status_vec = state_q.status;
    assign sticky_vec = state_q.sticky;
endmodule

// File: rtl/irq_group_agg_chk.sv
module irq_group_agg_chk #(
    parameter int W  = irq_agg_pkg::AGG_W,
    parameter int AW = irq_agg_pkg::AGG_AW
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  src_i,
    input logic          req_valid,
    input logic          req_ready,
    input logic          req_write,
    input logic [AW-1:0] req_addr,
    input logic [W-1:0]  req_wdata,
    input logic          rd_valid,
    input logic [W-1:0]  rd_data,
    input logic          irq_o,
    input logic [W-1:0]  status_vec,
    input logic [W-1:0]  sticky_vec
);
    localparam logic [AW-1:0] ST_OFF = AW'(4);
    localparam logic [AW-1:0] EN_OFF = AW'(0);

    logic st_wr, quiet, mapped;
    assign st_wr  = req_valid && req_write && (req_addr == ST_OFF);
    assign quiet  = (src_i & sticky_vec) == '0;
    assign mapped = (req_addr == ST_OFF) || (req_addr == EN_OFF);

    assert_ready_R11: assert property (@(posedge clk) disable iff (!rst_n) req_ready);

    assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !mapped) |=> rd_data == '0);

    assert_status_implies_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_vec != '0) |-> irq_o);

    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status_vec != '0 && !st_wr) |=> $stable(status_vec));

    assert_zero_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && req_wdata == '0 && quiet) |=> ($stable(status_vec) && $stable(irq_o)));

    assert_init_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && req_wdata == '1 && quiet) |=> (status_vec == '0 && $stable(irq_o)));
endmodule

bind irq_group_agg irq_group_agg_chk #(.W(W), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_i),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .irq_o      (irq_o),
    .status_vec (status_vec),
    .sticky_vec (sticky_vec)
);

// File: tb/tb_irq_group_agg.sv
module tb_irq_group_agg;
    localparam int W  = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  src_i = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [W-1:0]  req_wdata = '0;
    logic          rd_valid;
    logic [W-1:0]  rd_data;
    logic          irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // behavioural reference state
    bit [31:0] m_en, m_stk, m_mask, m_pend, m_st, m_rdd;
    bit        m_irq, m_rdv;

    always #10 clk = ~clk;

    irq_group_agg #(.W(W), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // advance the model by one clock with the current inputs
    task automatic model_step(input bit [31:0] s, input bit v, input bit w, input bit [3:0] a, input bit [31:0] d);
        bit [31:0] hit, chg;
        m_rdv = v && !w;
        m_rdd = 0;
        if (v && !w) m_rdd = (a == 0) ? m_en : (a == 4) ? m_st : 32'h0;
        if (v && w && a == 0) begin
            if (d == 0 && m_stk == 0) m_en = 0;
            else if ((m_stk | d) != m_stk) begin m_stk |= d; m_en = d; end
            else begin
                chg = m_en ^ d;
                if ((chg & d) != 0) m_mask &= ~chg; else m_mask |= chg;
                m_en = d;
            end
        end
        if (v && w && a == 4 && d != 0) begin
            m_st &= ~d;
            if (d != 32'hFFFF_FFFF && m_st == 0) begin
                if (m_pend != 0) begin m_st = m_pend; m_pend = 0; m_irq = 1; end
                else m_irq = 0;
            end
        end
        hit = s & m_stk;
        if (hit != 0) begin
            if (m_mask != 0 || m_st != 0) m_pend |= hit;
            else begin m_st = hit; m_irq = 1; end
        end
    endtask

    // one clock: drive at negedge, compare on the following negedge
    task automatic cyc(input bit [31:0] s, input bit v, input bit w, input bit [3:0] a, input bit [31:0] d);
        src_i = s; req_valid = v; req_write = w; req_addr = a; req_wdata = d;
        model_step(s, v, w, a, d);
        @(posedge clk);
        @(negedge clk);
        src_i = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
        check(irq_o == m_irq, "R3/R9 irq per-cycle", {31'b0, irq_o}, {31'b0, m_irq});
        check(rd_valid == m_rdv, "R11 rd_valid per-cycle", {31'b0, rd_valid}, {31'b0, m_rdv});
        if (m_rdv) check(rd_data == m_rdd, "R11 rd_data per-cycle", rd_data, m_rdd);
    endtask

    task automatic wr(input bit [3:0] a, input bit [31:0] d);
        cyc(0, 1, 1, a, d);
    endtask

    task automatic rd_chk(input bit [3:0] a, input bit [31:0] exp, input string tag);
        cyc(0, 1, 0, a, 0);
        check(rd_data == exp, tag, rd_data, exp);
    endtask

    task automatic irq_chk(input bit exp, input string tag);
        check(irq_o == exp, tag, {31'b0, irq_o}, {31'b0, exp});
    endtask

    initial begin
        m_en = 0; m_stk = 0; m_mask = 0; m_pend = 0; m_st = 0; m_rdd = 0;
        m_irq = 0; m_rdv = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        irq_chk(0, "R1 irq after reset");
        rd_chk(0, 0, "R1 enable reads zero");
        rd_chk(4, 0, "R1 status reads zero");
        check(req_ready == 1'b1, "R11 ready high", {31'b0, req_ready}, 32'h1);

        // R5 zero enable write with empty sticky vector
        wr(0, 0);
        rd_chk(0, 0, "R5 zero enable stored");
        // R2 line without enable is ignored
        cyc(32'h1, 0, 0, 0, 0);
        rd_chk(4, 0, "R2 unenabled line ignored");
        irq_chk(0, "R2 irq stays low");

        // R5 enable new bits
        wr(0, 32'hF);
        rd_chk(0, 32'hF, "R5 enable readback");
        cyc(32'h1, 0, 0, 0, 0);
        irq_chk(1, "R3 irq raised");
        rd_chk(4, 32'h1, "R3 status latched");
        cyc(32'h2, 0, 0, 0, 0);
        rd_chk(4, 32'h1, "R4 status unchanged while busy");
        wr(4, 0);
        rd_chk(4, 32'h1, "R7 zero status write ignored");
        wr(4, 32'h1);
        irq_chk(1, "R9 irq kept by pending reload");
        rd_chk(4, 32'h2, "R9 pending moved to status");
        wr(4, 32'h2);
        irq_chk(0, "R9 irq drops with empty pending");

        // R6 mask bit 3 by turning it off, then a masked-mode event
        wr(0, 32'h7);
        cyc(32'h1, 0, 0, 0, 0);
        rd_chk(4, 0, "R6 masked event goes to pending");
        irq_chk(0, "R6 no irq while masked");
        wr(0, 32'hF);
        cyc(32'h4, 0, 0, 0, 0);
        rd_chk(4, 32'h4, "R6 unmask restores direct latch");
        wr(4, 32'h4);
        rd_chk(4, 32'h1, "R9 earlier pending reloaded");
        wr(4, 32'h1);
        irq_chk(0, "R9 idle again");

        // R8 all-ones initialization
        cyc(32'h1, 0, 0, 0, 0);
        cyc(32'h2, 0, 0, 0, 0);
        wr(4, 32'hFFFF_FFFF);
        rd_chk(4, 0, "R8 all ones clears status");
        irq_chk(1, "R8 irq unchanged");
        cyc(32'h8, 0, 0, 0, 0);
        rd_chk(4, 32'h8, "R8 pending kept, new event latched");
        wr(4, 32'h8);
        rd_chk(4, 32'h2, "R8 pending survived init clear");
        wr(4, 32'h2);
        irq_chk(0, "R9 cleared after init sequence");

        // R10 write and event in the same cycle
        cyc(32'h1, 0, 0, 0, 0);
        cyc(32'h4, 1, 1, 4, 32'h1);
        irq_chk(1, "R10 event after write re-raises");
        rd_chk(4, 32'h4, "R10 status holds new event");
        wr(4, 32'h4);

        // R11 unmapped offset
        wr(8, 32'hDEAD_BEEF);
        rd_chk(8, 0, "R11 unmapped reads zero");
        rd_chk(0, 32'hF, "R11 unmapped write ignored");

        // R6 zero enable write with sticky set masks all stored bits
        wr(0, 0);
        cyc(32'h1, 0, 0, 0, 0);
        rd_chk(4, 0, "R6 zero enable write masks");
        irq_chk(0, "R6 masked group silent");
        repeat (2) cyc(0, 0, 0, 0, 0);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule